// File: doc/BRIEF.md
# Split-Operand Signed Multiplier, 36 x 36 to 72 bits

This block forms the exact 72-bit two's-complement product of two 36-bit signed operands without a wide multiply operator. Each operand is cut into an upper half, which is treated as signed, and a lower half, which is treated as unsigned. Only half-width partial products are formed. They are then shifted into place and summed.

A build parameter picks the partial-product scheme. The four-product scheme multiplies every pairing of halves and adds the two cross terms. The three-product scheme multiplies the sums of the halves, then subtracts the upper-by-upper and lower-by-lower products to recover the cross term. This saves one narrow multiplier at the cost of two adders and two subtractors.

The interface has no backpressure. An operand pair with its valid strobe may be presented on every cycle. The matching product appears with its own valid strobe exactly three cycles later, after an input register stage, a multiply stage and a summing stage. The product register holds its value between valid results.

Top module: `wide_smul`

## Requirements
- R1: In four-product mode (MODE = MODE_FOUR, encoded 0), out_prod equals the exact signed product in_a * in_b, read as a 72-bit two's-complement value, for any pair of operands.
- R2: In three-product mode (MODE = MODE_THREE, encoded 1), out_prod equals the same exact signed product for any pair of operands.
- R3: out_valid is high in cycle c+3 exactly when in_valid was high in cycle c. Operand pairs presented on consecutive cycles yield their products on consecutive cycles, in the same order.
- R4: When both operands are the most negative value, -2^35 (in_a = in_b = 36'h8_0000_0000), out_prod is +2^70, which is 72'h40_0000_0000_0000_0000.
- R5: When either operand is zero, out_prod is zero.
- R6: When the operands have opposite signs and neither is zero, out_prod is negative (bit 71 set) and exact. When both have the same sign and neither is zero, bit 71 is clear.
- R7: While rst_n is low and right after it rises, out_valid is 0 and out_prod is 0.
- R8: Operands presented while in_valid is low are ignored. out_prod keeps the last valid product until a new valid pair has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair on in_a and in_b is valid this cycle |
| in_a | input | 36 | Multiplicand, two's complement |
| in_b | input | 36 | Multiplier, two's complement |
| out_valid | output | 1 | out_prod carries a new product this cycle |
| out_prod | output | 72 | Exact signed product, two's complement |

## Verification
Four properties are checked on every cycle:
- the three-cycle valid latency;
- a zero result whenever an operand was zero;
- a sign bit matching the operand signs;
- low 18 product bits equal to the lower-by-lower partial product, and the output holding steady between valid results.

The assertions cannot show that the full 72-bit value is exact. The bench's scenarios show this in both schemes, using random operands, the most-negative square, zero operands, mixed signs and a back-to-back stream. The scenarios also confirm that operands presented without a strobe leave the held output alone.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

  typedef enum logic {
    MODE_FOUR  = 1'b0,
    MODE_THREE = 1'b1
  } mul_mode_e;

  // Predicts the outcome class of a signed product from operand signs and
  // zero flags: bit 1 = product is zero, bit 0 = product is negative.
  function automatic logic [1:0] sign_hint(input logic a_neg, input logic b_neg,
                                           input logic a_nil, input logic b_nil);
    logic nil;
    nil = a_nil | b_nil;
    return {nil, (a_neg ^ b_neg) & ~nil};
  endfunction

endpackage

// File: rtl/wsm_split.sv
module wsm_split #(
  parameter int OPW = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [OPW-1:0]          in_a,
  input  logic [OPW-1:0]          in_b,
  output logic                    s1_valid,
  output logic signed [OPW/2-1:0] a_hi,
  output logic [OPW/2-1:0]        a_lo,
  output logic signed [OPW/2-1:0] b_hi,
  output logic [OPW/2-1:0]        b_lo,
  output logic                    s1_nil,
  output logic                    s1_neg
);
  localparam int H = OPW / 2;

  logic [OPW-1:0] a_q, b_q;
  logic [1:0]     hint;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        a_q <= in_a;
        b_q <= in_b;
      end
    end
  end

  assign a_hi = $signed(a_q[OPW-1:H]);
  assign a_lo = a_q[H-1:0];
  assign b_hi = $signed(b_q[OPW-1:H]);
  assign b_lo = b_q[H-1:0];

  assign hint   = wsm_pkg::sign_hint(a_q[OPW-1], b_q[OPW-1], a_q == '0, b_q == '0);
  assign s1_nil = hint[1];
  assign s1_neg = hint[0];

endmodule

// File: rtl/wsm_partials.sv
module wsm_partials #(
  parameter int                  H    = 18,
  parameter wsm_pkg::mul_mode_e  MODE = wsm_pkg::MODE_FOUR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s1_valid,
  input  logic signed [H-1:0]    a_hi,
  input  logic [H-1:0]           a_lo,
  input  logic signed [H-1:0]    b_hi,
  input  logic [H-1:0]           b_lo,
  input  logic                   s1_nil,
  input  logic                   s1_neg,
  output logic                   s2_valid,
  output logic signed [2*H-1:0]  hh,
  output logic [2*H-1:0]         ll,
  output logic signed [2*H+3:0]  mx,
  output logic                   s2_nil,
  output logic                   s2_neg
);
  localparam int HW = 2 * H;
  localparam int CW = 2 * H + 4;
  localparam int SW = H + 2;

  logic signed [HW-1:0] hh_d;
  logic [HW-1:0]        ll_d;
  logic signed [CW-1:0] mx_d;

  // Upper halves are signed, lower halves unsigned.
  assign hh_d = HW'(a_hi) * HW'(b_hi);
  assign ll_d = HW'(a_lo) * HW'(b_lo);

  generate
    if (MODE == wsm_pkg::MODE_THREE) begin : g_three
      // Sum of halves spans one bit more than the half plus a sign bit.
      logic signed [SW-1:0] sa, sb;
      assign sa   = SW'(a_hi) + $signed({2'b00, a_lo});
      assign sb   = SW'(b_hi) + $signed({2'b00, b_lo});
      assign mx_d = CW'(sa) * CW'(sb);
    end else begin : g_four
      logic signed [CW-1:0] c_ab, c_ba;
      assign c_ab = CW'(a_hi) * CW'($signed({1'b0, b_lo}));
      assign c_ba = CW'(b_hi) * CW'($signed({1'b0, a_lo}));
      assign mx_d = c_ab + c_ba;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      hh       <= '0;
      ll       <= '0;
      mx       <= '0;
      s2_nil   <= 1'b0;
      s2_neg   <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        hh     <= hh_d;
        ll     <= ll_d;
        mx     <= mx_d;
        s2_nil <= s1_nil;
        s2_neg <= s1_neg;
      end
    end
  end

endmodule

// File: rtl/wsm_combine.sv
module wsm_combine #(
  parameter int                  H    = 18,
  parameter wsm_pkg::mul_mode_e  MODE = wsm_pkg::MODE_FOUR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s2_valid,
  input  logic signed [2*H-1:0]  hh,
  input  logic [2*H-1:0]         ll,
  input  logic signed [2*H+3:0]  mx,
  input  logic                   s2_nil,
  input  logic                   s2_neg,
  output logic                   out_valid,
  output logic [4*H-1:0]         out_prod
);
  localparam int HW = 2 * H;
  localparam int CW = 2 * H + 4;
  localparam int PW = 4 * H;

  logic signed [CW-1:0] mid;
  logic [PW-1:0]        sum_d;
  logic                 nil_q, neg_q;

  generate
    if (MODE == wsm_pkg::MODE_THREE) begin : g_three
      // Cross term recovered from the product of sums.
      assign mid = mx - CW'(hh) - $signed(CW'(ll));
    end else begin : g_four
      assign mid = mx;
    end
  endgenerate

  assign sum_d = (PW'(hh) << HW) + (PW'(mid) << H) + PW'(ll);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
      nil_q     <= 1'b0;
      neg_q     <= 1'b0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) begin
        out_prod <= sum_d;
        nil_q    <= s2_nil;
        neg_q    <= s2_neg;
      end
    end
  end

  // Zero operand must give a zero product.
  assert_zero_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nil_q) |-> (out_prod == '0));

  // Sign of a nonzero product follows the operand signs.
  assert_sign_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !nil_q) |-> (out_prod[PW-1] == neg_q));

  // Lowest half of the product comes only from the lower-by-lower term.
  assert_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> (out_prod[H-1:0] == $past(ll[H-1:0])));

  // Output holds between valid results.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> $stable(out_prod));

endmodule

// File: rtl/wide_smul.sv
module wide_smul #(
  parameter int                  OPW  = 36,
  parameter wsm_pkg::mul_mode_e  MODE = wsm_pkg::MODE_FOUR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             out_valid,
  output logic [2*OPW-1:0] out_prod
);
  localparam int H  = OPW / 2;
  localparam int HW = 2 * H;
  localparam int CW = 2 * H + 4;

  logic                 s1_valid, s1_nil, s1_neg;
  logic signed [H-1:0]  a_hi, b_hi;
  logic [H-1:0]         a_lo, b_lo;
  logic                 s2_valid, s2_nil, s2_neg;
  logic signed [HW-1:0] hh;
  logic [HW-1:0]        ll;
  logic signed [CW-1:0] mx;

  wsm_split #(.OPW(OPW)) u_split (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .s1_valid(s1_valid), .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .s1_nil(s1_nil), .s1_neg(s1_neg)
  );

  wsm_partials #(.H(H), .MODE(MODE)) u_partials (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .s1_nil(s1_nil), .s1_neg(s1_neg),
    .s2_valid(s2_valid), .hh(hh), .ll(ll), .mx(mx),
    .s2_nil(s2_nil), .s2_neg(s2_neg)
  );

  wsm_combine #(.H(H), .MODE(MODE)) u_combine (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid),
    .hh(hh), .ll(ll), .mx(mx), .s2_nil(s2_nil), .s2_neg(s2_neg),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  // Fixed three-cycle latency, both for a strobe and for its absence.
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

endmodule

// File: tb/sim_wide_smul.sv
module sim_wide_smul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [35:0] in_a = '0, in_b = '0;
  logic        v0, v1;
  logic [71:0] p0, p1;
  int          n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  wide_smul #(.OPW(36), .MODE(wsm_pkg::MODE_FOUR)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(v0), .out_prod(p0));

  wide_smul #(.OPW(36), .MODE(wsm_pkg::MODE_THREE)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(v1), .out_prod(p1));

  function automatic logic [71:0] ref_mul(input logic [35:0] a, input logic [35:0] b);
    logic signed [71:0] ea, eb;
    ea = $signed({{36{a[35]}}, a});
    eb = $signed({{36{b[35]}}, b});
    return ea * eb;
  endfunction

  task automatic chk(input string req, input logic [71:0] got, input logic [71:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // One pulse, checks the strobe before, at and after the result cycle.
  task automatic t_pair(input logic [35:0] a, input logic [35:0] b, input string req);
    logic [71:0] e;
    e = ref_mul(a, b);
    @(negedge clk); in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk("R3 early", {71'd0, v0 | v1}, 72'd0);
    @(negedge clk);
    chk("R3 valid", {70'd0, v0, v1}, 72'd3);
    chk({req, " R1 four-product"}, p0, e);
    chk({req, " R2 three-product"}, p1, e);
    @(negedge clk);
    chk("R3 single", {71'd0, v0 | v1}, 72'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7 valid in reset", {70'd0, v0, v1}, 72'd0);
    chk("R7 prod in reset", p0 | p1, 72'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 valid after reset", {70'd0, v0, v1}, 72'd0);
    chk("R7 prod after reset", p0 | p1, 72'd0);
  endtask

  task automatic t_corners();
    t_pair(36'h8_0000_0000, 36'h8_0000_0000, "R4");
    chk("R4 constant", p0, 72'h40_0000_0000_0000_0000);
    chk("R4 constant three", p1, 72'h40_0000_0000_0000_0000);
    t_pair(36'd0, 36'h8_0000_0000, "R5");
    chk("R5 zero a", p0 | p1, 72'd0);
    t_pair(36'h7_FFFF_FFFF, 36'd0, "R5");
    chk("R5 zero b", p0 | p1, 72'd0);
    t_pair(-36'sd5, 36'd7, "R6");
    chk("R6 neg sign", {71'd0, p0[71] & p1[71]}, 72'd1);
    t_pair(36'h7_FFFF_FFFF, 36'h8_0000_0000, "R6");
    t_pair(36'h8_0000_0000, 36'hF_FFFF_FFFF, "R6");
    t_pair(36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, "R6");
    chk("R6 pos sign", {71'd0, p0[71] | p1[71]}, 72'd0);
    t_pair(36'h0_0003_FFFF, 36'h0_0003_FFFF, "R1 half carry");
    t_pair(36'hF_FFFC_0000, 36'h0_0002_0001, "R6 half");
  endtask

  task automatic t_random();
    for (int i = 0; i < 24; i++) begin
      logic [63:0] r1, r2;
      r1 = {$urandom(), $urandom()};
      r2 = {$urandom(), $urandom()};
      t_pair(r1[35:0], r2[35:0], "R1/R2 random");
    end
  endtask

  task automatic t_stream();
    logic [35:0] sa [8];
    logic [35:0] sb [8];
    for (int i = 0; i < 8; i++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      sa[i] = r[35:0];
      sb[i] = r[63:28];
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k >= 3 && k < 11) begin
        chk("R3 stream valid", {70'd0, v0, v1}, 72'd3);
        chk("R3 stream order R1", p0, ref_mul(sa[k-3], sb[k-3]));
        chk("R3 stream order R2", p1, ref_mul(sa[k-3], sb[k-3]));
      end else if (k == 11) begin
        chk("R3 stream end", {70'd0, v0, v1}, 72'd0);
      end
      if (k < 8) begin
        in_a = sa[k]; in_b = sb[k]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_hold();
    logic [71:0] e;
    t_pair(36'd123456789, -36'sd987, "R8 setup");
    e = ref_mul(36'd123456789, -36'sd987);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_a = 36'h8_0000_0000 + 36'(i); in_b = 36'h5_5555_5555; in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R8 ignored valid", {70'd0, v0, v1}, 72'd0);
    chk("R8 held four", p0, e);
    chk("R8 held three", p1, e);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_stream();
    t_hold();
    summary();
    $finish;
  end

endmodule